// File: doc/BRIEF.md
# TDM Time-Slot Router

This block sits between one framed serial TDM line and a small set of internal serial channels. It walks a programmable table of routing entries one bit per clock. Receive and transmit each have their own table. Each entry names a run length, counted in bits or in bytes, and the internal channel that owns that run, or no channel at all. An entry can also drive a 2-bit external strobe, loop its slot back internally, and mark the end of the frame. A frame begins on a sync pulse, optionally one clock late. It ends after the entry flagged as last, and the sequencer then returns to entry 0 and waits for the next sync.

Each direction's table holds two banks. The host edits the idle bank and then requests a swap. The swap takes effect only when both directions sit between frames. The whole interface can be put in echo mode or loopback mode for test.

The host programs entries through a single write port. It selects the direction with `tbl_dir` (0 receive, 1 transmit) and the slot with `tbl_addr`, whose top bit chooses the bank. The channels see one shared receive data bit, a per-channel receive enable, per-channel transmit data bits and a per-channel transmit enable.

Top module: `tdm_slot_router`

## Requirements
- R1: While and right after reset, all channel enables and strobes are 0, `txd_out` is 1 and `active_bank` is 0.
- R2: An entry is packed as [3:0] count n, [4] unit (1 = bytes), [7:5] channel, [9:8] strobe, [10] loop, [11] last. It occupies n+1 bit times, or 8*(n+1) when the unit bit is set. During that run, the enable of its channel is high for exactly that many consecutive clocks.
- R3: Channel code 7, or any code not below NCH, routes to no channel. No enable rises during that slot, and on transmit the line stays high.
- R4: With `sof_delay` = 0 the first frame bit is carried in the clock where sync is high. With `sof_delay` = 1 it is carried one clock later.
- R5: After the last bit of the entry flagged last, all enables stay low until a new sync arrives. The next frame starts again from entry 0.
- R6: A sync pulse arriving while a frame is being routed has no effect on the routing of that frame.
- R7: With `sof_delay` = 1, a sync that coincides with the last bit of a frame is accepted, and the next frame's first bit follows on the next clock. With `sof_delay` = 0 such a sync is ignored.
- R8: In normal mode (`test_mode` = 0), `txd_out` carries `chan_tx_data` of the channel owning the current transmit slot. Outside routed slots it is 1, and a channel's transmit enable is high only in its own slots.
- R9: `rx_strobe` and `tx_strobe` carry the strobe field of the current entry during a frame, and are 0 outside frames.
- R10: With `test_mode` = 1 (echo), `txd_out` equals `rxd_in` at all times, while receive routing continues.
- R11: With `test_mode` = 2 (loopback), `txd_out` is held at 1 and the receive path takes its data from the internal transmit stream instead of `rxd_in`.
- R12: A receive entry with its loop bit set takes the internal transmit stream as receive data for that slot only. A transmit entry with its loop bit set keeps `txd_out` at 1 for that slot.
- R13: A `swap_req` pulse toggles the active bank only at a clock where neither direction is inside or about to enter a frame. `active_bank` reports the bank in use, and `tbl_addr` bit 5 selects bank 1 when writing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock shared by receive and transmit |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Frame sync pulse shared by both directions |
| rxd_in | input | 1 | Serial receive data from the line |
| txd_out | output | 1 | Serial transmit data to the line, idle high |
| sof_delay | input | 1 | 0: frame starts with sync, 1: one clock later |
| test_mode | input | 2 | 0 normal, 1 echo, 2 loopback, 3 normal |
| tbl_we | input | 1 | Table write strobe |
| tbl_dir | input | 1 | Table select, 0 receive, 1 transmit |
| tbl_addr | input | $clog2(DEPTH) | Entry address, top bit is the bank |
| tbl_wdata | input | 12 | Entry contents |
| swap_req | input | 1 | Request to switch banks at the next frame gap |
| active_bank | output | 1 | Bank currently used for routing |
| chan_rx_data | output | 1 | Receive bit presented to all channels |
| chan_rx_en | output | NCH | Per-channel receive enable |
| chan_tx_data | input | NCH | Per-channel transmit bit |
| chan_tx_en | output | NCH | Per-channel transmit enable |
| rx_strobe | output | 2 | Receive strobe field of current entry |
| tx_strobe | output | 2 | Transmit strobe field of current entry |

## Verification
The bench targets the run-length arithmetic at its extremes: a single bit, sixteen bits, one byte and sixteen bytes. A wrong byte multiplier or an off-by-one end test shows up there as a run that is too short or too long. It places sync pulses in mid-frame and on the final bit, under both delay settings. A design that restarts on any sync would cut the frame short, and one that drops the overlapped sync would leave a gap or miss a frame. It requests a bank swap in mid-frame and watches when the bank flips. An early swap would route the rest of the frame from the wrong table. Echo, loopback and per-slot loop are each checked against values that differ from the idle level, so a design that silently kept the normal path would be caught.

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
  parameter int NCH   = 4,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic                     rxd_in,
  output logic                     txd_out,
  input  logic                     sof_delay,
  input  logic [1:0]               test_mode,
  input  logic                     tbl_we,
  input  logic                     tbl_dir,
  input  logic [$clog2(DEPTH)-1:0] tbl_addr,
  input  logic [11:0]              tbl_wdata,
  input  logic                     swap_req,
  output logic                     active_bank,
  output logic                     chan_rx_data,
  output logic [NCH-1:0]           chan_rx_en,
  input  logic [NCH-1:0]           chan_tx_data,
  output logic [NCH-1:0]           chan_tx_en,
  output logic [1:0]               rx_strobe,
  output logic [1:0]               tx_strobe
);
  localparam int BANKD = DEPTH / 2;
  localparam int AW    = $clog2(BANKD);

  logic [11:0]    tbl [2][DEPTH];
  logic [11:0]    ent [2];
  logic [NCH-1:0] en_v [2];
  logic [1:0]     go, fin, nrun, npend;
  logic           bank, swap_pend, idle_next;
  logic           tx_line;

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_dir][tbl_addr] <= tbl_wdata;

  for (genvar d = 0; d < 2; d++) begin : g_seq
    logic          run, pend, eoe;
    logic [AW-1:0] ix;
    logic [6:0]    ct, len_m1;

    assign ent[d]   = tbl[d][{bank, ix}];
    assign len_m1   = ent[d][4] ? {ent[d][3:0], 3'b111} : {3'b000, ent[d][3:0]};
    assign go[d]    = run | pend | (sync_in & ~sof_delay);
    assign eoe      = (ct == len_m1);
    assign fin[d]   = go[d] & eoe & ent[d][11];
    assign nrun[d]  = go[d] & ~fin[d];
    assign npend[d] = sync_in & sof_delay & (~go[d] | fin[d]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run  <= 1'b0;
        pend <= 1'b0;
        ix   <= '0;
        ct   <= '0;
      end else begin
        run  <= nrun[d];
        pend <= npend[d];
        if (go[d]) begin
          if (eoe) begin
            ct <= '0;
            ix <= fin[d] ? '0 : ix + 1'b1;
          end else begin
            ct <= ct + 1'b1;
          end
        end
      end
    end

    always_comb
      for (int c = 0; c < NCH; c++)
        en_v[d][c] = go[d] && (ent[d][7:5] == 3'(c));
  end

  assign idle_next = ~|nrun & ~|npend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank      <= 1'b0;
      swap_pend <= 1'b0;
    end else if ((swap_pend | swap_req) && idle_next) begin
      bank      <= ~bank;
      swap_pend <= 1'b0;
    end else if (swap_req) begin
      swap_pend <= 1'b1;
    end
  end

  assign tx_line      = ~|(en_v[1] & ~chan_tx_data);
  assign txd_out      = (test_mode == 2'd1) ? rxd_in :
                        (test_mode == 2'd2) ? 1'b1 :
                        (go[1] & ent[1][10]) ? 1'b1 : tx_line;
  assign chan_rx_data = ((test_mode == 2'd2) || (go[0] & ent[0][10])) ? tx_line : rxd_in;
  assign chan_rx_en   = en_v[0];
  assign chan_tx_en   = en_v[1];
  assign rx_strobe    = go[0] ? ent[0][9:8] : 2'b00;
  assign tx_strobe    = go[1] ? ent[1][9:8] : 2'b00;
  assign active_bank  = bank;
endmodule

module tdm_slot_router_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rxd_in,
  input logic           txd_out,
  input logic [1:0]     test_mode,
  input logic [NCH-1:0] chan_rx_en,
  input logic [NCH-1:0] chan_tx_en
);
  a_r3_rx_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_rx_en));
  a_r3_tx_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_tx_en));
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'd0 && chan_tx_en == '0) |-> txd_out);
  a_r10_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'd1) |-> (txd_out == rxd_in));
  a_r11_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'd2) |-> txd_out);
endmodule

bind tdm_slot_router tdm_slot_router_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .txd_out(txd_out),
  .test_mode(test_mode), .chan_rx_en(chan_rx_en), .chan_tx_en(chan_tx_en)
);

// File: tb/tdm_slot_router_test.sv
module tdm_slot_router_test;
  localparam int NCH = 4;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, rxd_in = 1'b0, sof_delay = 1'b0;
  logic [1:0] test_mode = 2'd0;
  logic tbl_we = 1'b0, tbl_dir = 1'b0, swap_req = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [11:0] tbl_wdata = '0;
  logic [NCH-1:0] chan_tx_data = '0;
  logic txd_out, active_bank, chan_rx_data;
  logic [NCH-1:0] chan_rx_en, chan_tx_en;
  logic [1:0] rx_strobe, tx_strobe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tdm_slot_router #(.NCH(NCH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rxd_in(rxd_in), .txd_out(txd_out),
    .sof_delay(sof_delay), .test_mode(test_mode), .tbl_we(tbl_we), .tbl_dir(tbl_dir),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .swap_req(swap_req),
    .active_bank(active_bank), .chan_rx_data(chan_rx_data), .chan_rx_en(chan_rx_en),
    .chan_tx_data(chan_tx_data), .chan_tx_en(chan_tx_en), .rx_strobe(rx_strobe),
    .tx_strobe(tx_strobe));

  // rows: {n[3:0], byte, ch[2:0], expected run length[7:0]}
  localparam logic [15:0] VEC [5] = '{
    {4'd0,  1'b0, 3'd1, 8'd1},
    {4'd15, 1'b0, 3'd2, 8'd16},
    {4'd0,  1'b1, 3'd3, 8'd8},
    {4'd2,  1'b1, 3'd2, 8'd24},
    {4'd15, 1'b1, 3'd0, 8'd128}
  };

  function automatic logic [11:0] ent(input logic last, input logic lp, input logic [1:0] stb,
                                      input logic [2:0] ch, input logic byt, input logic [3:0] n);
    return {last, lp, stb, ch, byt, n};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic dir, input logic [5:0] addr, input logic [11:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_dir = dir; tbl_addr = addr; tbl_wdata = data;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_in = 1'b0; swap_req = 1'b0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic logic [3:0] rx_exp(input int c);
    if (c <= 2) return 4'b0010;
    if (c == 5 || c == 6) return 4'b0100;
    return 4'b0000;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    #1;
    check("R1 rx_en in reset", chan_rx_en, 0);
    check("R1 txd in reset", txd_out, 1);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 bank after reset", active_bank, 0);
    check("R1 strobes after reset", {rx_strobe, tx_strobe}, 0);
    check("R1 tx_en after reset", chan_tx_en, 0);

    wr(1'b1, 6'd0, ent(1, 0, 0, 3'd7, 0, 4'd0));
    foreach (VEC[v]) begin
      wr(1'b0, 6'd0, ent(1, 0, 0, VEC[v][10:8], VEC[v][11], VEC[v][15:12]));
      idle(2);
      cnt = 0;
      for (int c = 0; c < 140; c++) begin
        @(negedge clk);
        sync_in = (c == 0);
        #1;
        if (c == 0) check("R2 first bit enable", chan_rx_en, 4'b1 << VEC[v][10:8]);
        if (chan_rx_en == (4'b1 << VEC[v][10:8])) cnt++;
      end
      check("R2 run length", cnt, VEC[v][7:0]);
    end

    wr(1'b0, 6'd0, ent(0, 0, 2'd1, 3'd1, 0, 4'd2));
    wr(1'b0, 6'd1, ent(0, 0, 2'd0, 3'd7, 0, 4'd1));
    wr(1'b0, 6'd2, ent(1, 0, 2'd2, 3'd2, 0, 4'd1));
    wr(1'b1, 6'd0, ent(0, 0, 2'd3, 3'd0, 0, 4'd3));
    wr(1'b1, 6'd1, ent(1, 0, 2'd0, 3'd3, 0, 4'd3));
    chan_tx_data = 4'b0001;
    idle(2);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      sync_in = (c == 0) || (c == 4);
      #1;
      check($sformatf("R2 R3 R5 R6 rx_en c%0d", c), chan_rx_en, rx_exp(c));
      check($sformatf("R8 tx_en c%0d", c), chan_tx_en, c < 4 ? 4'b0001 : c < 8 ? 4'b1000 : 4'b0000);
      check($sformatf("R8 R3 txd c%0d", c), txd_out, (c < 4 || c >= 8) ? 1 : 0);
      if (c == 0) check("R9 strobes first slot", {rx_strobe, tx_strobe}, 4'b0111);
      if (c == 3) check("R9 rx strobe none slot", rx_strobe, 0);
      if (c == 5) check("R9 rx strobe third slot", rx_strobe, 2);
      if (c == 9) check("R9 strobes after frame", {rx_strobe, tx_strobe}, 0);
    end

    sof_delay = 1'b1;
    idle(3);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      sync_in = (c == 0) || (c == 7);
      #1;
      if (c == 0) check("R4 delayed start c0", chan_rx_en, 0);
      if (c == 1) check("R4 delayed start c1", chan_rx_en, 4'b0010);
      if (c == 7) check("R7 last bit c7", chan_rx_en, 4'b0100);
      if (c == 8) check("R7 overlap restart c8", chan_rx_en, 4'b0010);
      if (c == 11) check("R7 second frame gap c11", chan_rx_en, 0);
      if (c == 14) check("R7 second frame end c14", chan_rx_en, 4'b0100);
      if (c == 15) check("R5 idle after frame c15", chan_rx_en, 0);
    end

    sof_delay = 1'b0;
    idle(3);
    cnt = 0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      sync_in = (c == 0) || (c == 6);
      #1;
      if (c >= 7 && chan_rx_en != 0) cnt++;
    end
    check("R7 overlap ignored without delay", cnt, 0);

    wr(1'b0, 6'd2, ent(1, 1, 2'd2, 3'd2, 0, 4'd1));
    wr(1'b1, 6'd1, ent(1, 1, 2'd0, 3'd3, 0, 4'd3));
    rxd_in = 1'b1;
    idle(2);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      sync_in = (c == 0);
      #1;
      if (c == 0) check("R12 normal slot rx data", chan_rx_data, 1);
      if (c == 5) check("R12 looped slot rx data", chan_rx_data, 0);
      if (c == 5) check("R12 looped tx slot pin high", txd_out, 1);
      if (c == 1) check("R12 unlooped tx slot", txd_out, 1);
    end
    wr(1'b1, 6'd1, ent(1, 0, 2'd0, 3'd3, 0, 4'd3));
    wr(1'b0, 6'd2, ent(1, 0, 2'd2, 3'd2, 0, 4'd1));

    test_mode = 2'd1;
    idle(2);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      sync_in = (c == 0);
      rxd_in = (c != 4);
      #1;
      if (c == 0) check("R10 echo rx routing", chan_rx_en, 4'b0010);
      if (c == 3) check("R10 echo high", txd_out, 1);
      if (c == 4) check("R10 echo low", txd_out, 0);
    end

    test_mode = 2'd2;
    rxd_in = 1'b0;
    idle(2);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      sync_in = (c == 0);
      #1;
      if (c == 0) check("R11 loopback rx data", chan_rx_data, 1);
      if (c == 0) check("R11 loopback rx routing", chan_rx_en, 4'b0010);
      if (c == 5) check("R11 loopback follows tx", chan_rx_data, 0);
      if (c == 4) check("R11 pin quiet", txd_out, 1);
    end
    test_mode = 2'd0;

    wr(1'b0, 6'd32, ent(1, 0, 0, 3'd3, 0, 4'd1));
    wr(1'b1, 6'd32, ent(1, 0, 0, 3'd7, 0, 4'd0));
    idle(2);
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      sync_in = (c == 0) || (c == 10);
      swap_req = (c == 1);
      #1;
      if (c == 1) check("R13 bank before request", active_bank, 0);
      if (c == 7) check("R13 no swap mid frame", active_bank, 0);
      if (c == 8) check("R13 swap at frame gap", active_bank, 1);
      if (c == 10) check("R13 new bank routing", chan_rx_en, 4'b1000);
      if (c == 12) check("R13 new bank frame end", chan_rx_en, 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule